// File: doc/BRIEF.md
# Digital I/O Register File

This block is the host-facing register set of a 56-line digital I/O card. The card has 24 latched output lines, 24 input-only lines, and 8 lines that can work as outputs or as inputs. The host reaches them through a simple synchronous byte bus. Each access presents a 4-bit address. A write strobe writes one data byte, and a read strobe returns one byte on the clock edge after the strobe. All input lines pass through a two-stage synchronizer before the host can read them.

The 8 shared lines have two registers. One holds the byte the block drives out. The other shows the byte the pins present. A direction bit in the control register turns on the pin drivers. Software reads one register or the other according to that bit. A control byte and an enable byte for the separate change-of-state block are kept here as well. A write of any value to the last offset restarts the board: it clears every latch, the control byte and the change-of-state enables, and it gives a one-cycle reset pulse to the neighbouring logic. A read of that same offset returns the live level of the card's interrupt line.

Top module: `dio_regfile`

## Requirements
- R1: Every output port is 0 while reset is active and after reset ends. This covers the latches, the direction enable, the change-of-state enables, the board-reset pulse and the read data.
- R2: A write to offset 0, 1 or 2 loads the byte for output lines 7..0, 15..8 or 23..16. The new value is on the output pins from the next cycle, and a read of the same offset returns it.
- R3: A write to offset 3 loads the shared-line output latch. The latch drives the shared output bus, and a read of offset 3 returns the latch in either direction mode.
- R4: Offset 12 is a read-write control byte. Bit 1 of that byte drives the shared-line output enable: 1 means output mode, 0 means input mode.
- R5: Offsets 4, 5 and 6 return input lines 7..0, 15..8 and 23..16, and offset 7 returns the shared-line pins. The value returned is the one the pins held two clock edges before the edge that takes the read strobe.
- R6: Writes to offsets 4 to 11 and 13 change no output and no register. Reads of offsets 8 to 11 and 13 return 0.
- R7: A write of any value to offset 15 clears the output latches (offsets 0 to 3), the control byte and the change-of-state enables at that same edge. It also raises the board-reset output for exactly one cycle.
- R8: A read of offset 15 returns the interrupt line level in bit 0, with bits 7 to 1 at 0.
- R9: Read data appears in the cycle after the read strobe and keeps its value until the next read strobe.
- R10: Offset 14 is a read-write byte that drives the change-of-state enable output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| out_pins | output | 24 | Latched output lines |
| in_pins | input | 24 | Input-only lines |
| bidir_out | output | 8 | Shared-line output latch |
| bidir_in | input | 8 | Shared-line pin levels |
| bidir_oe | output | 1 | Shared-line driver enable |
| irq_level | input | 1 | Interrupt line level |
| cos_enable | output | 8 | Change-of-state enables |
| board_reset | output | 1 | One-cycle board reset pulse |

## Verification
The assertions check the following on every cycle:
- writes to the first output byte and to the direction bit take effect one cycle later;
- ignored offsets leave every output stable;
- a board-reset write clears the state and raises a single pulse;
- read data holds between strobes;
- offset 15 returns the interrupt line;
- input reads return the pins as they were two edges before the read edge.

Some behaviour needs a sequence of accesses, so only the bench's scenarios can show it:
- the byte order of the wide latch and input buses;
- reading the shared lines through both offsets in both modes;
- the control and enable bytes reading back;
- reserved offsets reading 0.

// File: rtl/dio_pkg.sv
package dio_pkg;
  localparam int OFS_CTRL  = 12;
  localparam int OFS_RSVD  = 13;
  localparam int OFS_COSEN = 14;
  localparam int OFS_BOARD = 15;
  localparam int DIR_BIT   = 1;
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dio_byte_regs.sv
module dio_byte_regs #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int NUM    = 1,
  parameter int BASE   = 0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [NUM*DATA_W-1:0] q
);
  for (genvar g = 0; g < NUM; g++) begin : g_byte
    logic [DATA_W-1:0] byte_q;
    always_ff @(posedge clk) begin
      if (rst || clr)
        byte_q <= '0;
      else if (wr_en && addr == ADDR_W'(BASE + g))
        byte_q <= wr_data;
    end
    assign q[g*DATA_W +: DATA_W] = byte_q;
  end
endmodule

// File: rtl/dio_rd_mux.sv
module dio_rd_mux #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int OUT_BYTES = 3,
  parameter int IN_BYTES  = 3
) (
  input  logic [ADDR_W-1:0]               addr,
  input  logic [(OUT_BYTES+1)*DATA_W-1:0] out_all,
  input  logic [(IN_BYTES+1)*DATA_W-1:0]  in_all,
  input  logic [DATA_W-1:0]               ctrl,
  input  logic [DATA_W-1:0]               cosen,
  input  logic                            irq,
  output logic [DATA_W-1:0]               data
);
  localparam int IN_BASE = OUT_BYTES + 1;

  always_comb begin
    data = '0;
    for (int i = 0; i <= OUT_BYTES; i++)
      if (addr == ADDR_W'(i)) data = out_all[i*DATA_W +: DATA_W];
    for (int i = 0; i <= IN_BYTES; i++)
      if (addr == ADDR_W'(IN_BASE + i)) data = in_all[i*DATA_W +: DATA_W];
    if (addr == ADDR_W'(dio_pkg::OFS_CTRL))  data = ctrl;
    if (addr == ADDR_W'(dio_pkg::OFS_COSEN)) data = cosen;
    if (addr == ADDR_W'(dio_pkg::OFS_BOARD)) data = {{(DATA_W-1){1'b0}}, irq};
  end
endmodule

// File: rtl/dio_regfile.sv
module dio_regfile #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int OUT_BYTES   = 3,
  parameter int IN_BYTES    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        wr_en,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic                        rd_en,
  output logic [DATA_W-1:0]           rd_data,
  output logic [OUT_BYTES*DATA_W-1:0] out_pins,
  input  logic [IN_BYTES*DATA_W-1:0]  in_pins,
  output logic [DATA_W-1:0]           bidir_out,
  input  logic [DATA_W-1:0]           bidir_in,
  output logic                        bidir_oe,
  input  logic                        irq_level,
  output logic [DATA_W-1:0]           cos_enable,
  output logic                        board_reset
);
  localparam int LAT_W = (OUT_BYTES + 1) * DATA_W;
  localparam int SMP_W = (IN_BYTES + 1) * DATA_W;

  logic              board_wr;
  logic [LAT_W-1:0]  lat_all;
  logic [SMP_W-1:0]  smp_all;
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] rd_next;

  assign board_wr = wr_en && (addr == ADDR_W'(dio_pkg::OFS_BOARD));

  dio_byte_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM(OUT_BYTES + 1), .BASE(0)) u_lat (
    .clk(clk), .rst(rst), .clr(board_wr), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .q(lat_all)
  );

  dio_byte_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM(1), .BASE(dio_pkg::OFS_CTRL)) u_ctrl (
    .clk(clk), .rst(rst), .clr(board_wr), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .q(ctrl_q)
  );

  dio_byte_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM(1), .BASE(dio_pkg::OFS_COSEN)) u_cosen (
    .clk(clk), .rst(rst), .clr(board_wr), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .q(cos_enable)
  );

  dio_sync #(.WIDTH(SMP_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({bidir_in, in_pins}), .q(smp_all)
  );

  dio_rd_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OUT_BYTES(OUT_BYTES), .IN_BYTES(IN_BYTES)) u_mux (
    .addr(addr), .out_all(lat_all), .in_all(smp_all), .ctrl(ctrl_q),
    .cosen(cos_enable), .irq(irq_level), .data(rd_next)
  );

  assign out_pins  = lat_all[OUT_BYTES*DATA_W-1:0];
  assign bidir_out = lat_all[OUT_BYTES*DATA_W +: DATA_W];
  assign bidir_oe  = ctrl_q[dio_pkg::DIR_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data     <= '0;
      board_reset <= 1'b0;
    end else begin
      board_reset <= board_wr;
      if (rd_en) rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/dio_regfile_chk.sv
module dio_regfile_chk #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int OUT_BYTES = 3,
  parameter int IN_BYTES  = 3
) (
  input logic                        clk,
  input logic                        rst,
  input logic [ADDR_W-1:0]           addr,
  input logic                        wr_en,
  input logic [DATA_W-1:0]           wr_data,
  input logic                        rd_en,
  input logic [DATA_W-1:0]           rd_data,
  input logic [OUT_BYTES*DATA_W-1:0] out_pins,
  input logic [IN_BYTES*DATA_W-1:0]  in_pins,
  input logic [DATA_W-1:0]           bidir_out,
  input logic [DATA_W-1:0]           bidir_in,
  input logic                        bidir_oe,
  input logic                        irq_level,
  input logic [DATA_W-1:0]           cos_enable,
  input logic                        board_reset
);
  localparam int IN_BASE = OUT_BYTES + 1;

  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  logic ign_wr;
  assign ign_wr = wr_en && ((addr >= ADDR_W'(IN_BASE) && addr < ADDR_W'(dio_pkg::OFS_CTRL)) ||
                            addr == ADDR_W'(dio_pkg::OFS_RSVD));

  // R2
  wr_lat0_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == '0) |=> out_pins[DATA_W-1:0] == $past(wr_data));

  // R4
  dir_follows_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(dio_pkg::OFS_CTRL)) |=> bidir_oe == $past(wr_data[dio_pkg::DIR_BIT]));

  // R6
  ignored_wr_chk: assert property (@(posedge clk) disable iff (rst)
    ign_wr |=> ($stable(out_pins) && $stable(bidir_out) && $stable(bidir_oe) && $stable(cos_enable)));

  // R7
  board_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(dio_pkg::OFS_BOARD)) |=>
      (out_pins == '0 && bidir_out == '0 && !bidir_oe && cos_enable == '0 && board_reset));

  // R7
  board_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == ADDR_W'(dio_pkg::OFS_BOARD)) |=> !board_reset);

  // R8
  irq_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(dio_pkg::OFS_BOARD)) |=>
      rd_data == {{(DATA_W-1){1'b0}}, $past(irq_level)});

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  // R5
  in_read_chk: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && rd_en && addr == ADDR_W'(IN_BASE)) |=>
      rd_data == $past(in_pins[DATA_W-1:0], 3));

  // R5
  bidir_in_read_chk: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && rd_en && addr == ADDR_W'(IN_BASE + IN_BYTES)) |=>
      rd_data == $past(bidir_in, 3));
endmodule

bind dio_regfile dio_regfile_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OUT_BYTES(OUT_BYTES), .IN_BYTES(IN_BYTES)
) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .out_pins(out_pins), .in_pins(in_pins),
  .bidir_out(bidir_out), .bidir_in(bidir_in), .bidir_oe(bidir_oe),
  .irq_level(irq_level), .cos_enable(cos_enable), .board_reset(board_reset)
);

// File: tb/test_dio_regfile.sv
module test_dio_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic [23:0] out_pins;
  logic [23:0] in_pins = '0;
  logic [7:0]  bidir_out;
  logic [7:0]  bidir_in = '0;
  logic        bidir_oe;
  logic        irq_level = 1'b0;
  logic [7:0]  cos_enable;
  logic        board_reset;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dio_regfile i_dio_regfile (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .out_pins(out_pins), .in_pins(in_pins),
    .bidir_out(bidir_out), .bidir_in(bidir_in), .bidir_oe(bidir_oe),
    .irq_level(irq_level), .cos_enable(cos_enable), .board_reset(board_reset)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic t_reset;
    chk("R1 out_pins", 32'(out_pins), 32'h0);
    chk("R1 bidir_out", 32'(bidir_out), 32'h0);
    chk("R1 bidir_oe", 32'(bidir_oe), 32'h0);
    chk("R1 cos_enable", 32'(cos_enable), 32'h0);
    chk("R1 board_reset", 32'(board_reset), 32'h0);
    chk("R1 rd_data", 32'(rd_data), 32'h0);
  endtask

  task automatic t_outputs;
    logic [7:0] v;
    bus_wr(4'd0, 8'hA5);
    bus_wr(4'd1, 8'h3C);
    bus_wr(4'd2, 8'hF0);
    chk("R2 out_pins order", 32'(out_pins), 32'hF03CA5);
    bus_rd(4'd0, v); chk("R2 read 0", 32'(v), 32'hA5);
    bus_rd(4'd1, v); chk("R2 read 1", 32'(v), 32'h3C);
    bus_rd(4'd2, v); chk("R2 read 2", 32'(v), 32'hF0);
  endtask

  task automatic t_bidir;
    logic [7:0] v;
    bus_wr(4'd3, 8'h5A);
    chk("R3 bidir_out", 32'(bidir_out), 32'h5A);
    bus_rd(4'd3, v); chk("R3 read latch in input mode", 32'(v), 32'h5A);
    bus_wr(4'd12, 8'h02);
    chk("R4 oe set", 32'(bidir_oe), 32'h1);
    bus_rd(4'd12, v); chk("R4 ctrl readback", 32'(v), 32'h02);
    bus_rd(4'd3, v); chk("R3 read latch in output mode", 32'(v), 32'h5A);
    bus_wr(4'd12, 8'hFD);
    chk("R4 oe clear with other bits set", 32'(bidir_oe), 32'h0);
    bus_rd(4'd12, v); chk("R4 ctrl readback 2", 32'(v), 32'hFD);
    bus_wr(4'd12, 8'h00);
  endtask

  task automatic t_inputs;
    logic [7:0] v;
    @(negedge clk);
    in_pins = 24'h123456; bidir_in = 8'hC3;
    repeat (2) @(negedge clk);
    bus_rd(4'd4, v); chk("R5 read 4", 32'(v), 32'h56);
    bus_rd(4'd5, v); chk("R5 read 5", 32'(v), 32'h34);
    bus_rd(4'd6, v); chk("R5 read 6", 32'(v), 32'h12);
    bus_rd(4'd7, v); chk("R5 read 7", 32'(v), 32'hC3);
  endtask

  task automatic t_ignored;
    logic [7:0] v;
    for (int a = 4; a < 12; a++) bus_wr(4'(a), 8'hFF);
    bus_wr(4'd13, 8'hFF);
    chk("R6 out_pins unchanged", 32'(out_pins), 32'hF03CA5);
    chk("R6 bidir_out unchanged", 32'(bidir_out), 32'h5A);
    chk("R6 oe unchanged", 32'(bidir_oe), 32'h0);
    chk("R6 cos_enable unchanged", 32'(cos_enable), 32'h0);
    bus_rd(4'd4, v); chk("R6 input still pins", 32'(v), 32'h56);
    bus_rd(4'd13, v); chk("R6 reserved reads 0", 32'(v), 32'h0);
    bus_rd(4'd9, v); chk("R6 offset 9 reads 0", 32'(v), 32'h0);
  endtask

  task automatic t_cos;
    logic [7:0] v;
    bus_wr(4'd14, 8'h33);
    chk("R10 cos_enable", 32'(cos_enable), 32'h33);
    bus_rd(4'd14, v); chk("R10 readback", 32'(v), 32'h33);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    irq_level = 1'b1;
    bus_rd(4'd15, v); chk("R8 irq high", 32'(v), 32'h01);
    irq_level = 1'b0;
    bus_rd(4'd15, v); chk("R8 irq low", 32'(v), 32'h00);
  endtask

  task automatic t_timing;
    logic [7:0] v;
    bus_rd(4'd1, v); chk("R9 read value", 32'(v), 32'h3C);
    bus_wr(4'd1, 8'h11);
    repeat (3) @(negedge clk);
    chk("R9 hold without strobe", 32'(rd_data), 32'h3C);
    bus_rd(4'd1, v); chk("R9 new read", 32'(v), 32'h11);
  endtask

  task automatic t_soft;
    bus_wr(4'd12, 8'h02);
    @(negedge clk);
    addr = 4'd15; wr_data = 8'h00; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R7 pulse high", 32'(board_reset), 32'h1);
    chk("R7 out_pins cleared", 32'(out_pins), 32'h0);
    chk("R7 bidir_out cleared", 32'(bidir_out), 32'h0);
    chk("R7 oe cleared", 32'(bidir_oe), 32'h0);
    chk("R7 cos_enable cleared", 32'(cos_enable), 32'h0);
    @(negedge clk);
    chk("R7 pulse one cycle", 32'(board_reset), 32'h0);
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_outputs;
    t_bidir;
    t_inputs;
    t_ignored;
    t_cos;
    t_irq;
    t_timing;
    t_soft;
    done = 1'b1;
    finish_run;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run;
    end
  end
endmodule